// File: doc/BRIEF.md
# Priority I/O Crossbar Pin Allocator

This block decides which on-chip peripheral signal drives each physical port pin. Configuration enables come in: one bit per resource, a channel count for the capture/compare group, a SPI slave-select mode and a per-pin skip mask. The allocator walks the enabled signals in a fixed priority order. Each signal takes the lowest-numbered pin that is neither skipped nor already taken. The one exception is the primary UART, whose two signals always sit on port pins 4 and 5.

For every pin the block produces a select code that names the peripheral signal driving it. Code 0 means plain GPIO. For every peripheral signal it produces a placed flag and the index of its pin, so that peripheral inputs can be multiplexed back from the pads. All inputs are static configuration and are handled as plain control pins, with no handshake. The outputs are registered once, so a configuration change shows up one clock later.

Top module: `prio_io_crossbar`

## Requirements
- R1: When `xbar_en` is 0, every `pin_sel` entry is 0 (GPIO), every `sig_valid` bit is 0 and `overflow` is 0.
- R2: When `xbar_en` and `uart_en` are both 1, pin 4 carries code 1 (UART transmit) and pin 5 carries code 2 (UART receive). This holds whatever the skip mask and the other enables are.
- R3: `overflow` is 1 exactly when at least one requested signal found no free pin. While it is 1, every pin is either skipped or carries a nonzero code.
- R4: Signals are placed in this order: SCK=3, MISO=4, MOSI=5, NSS=6, SDA=7, SCL=8, comparator=9, capture/compare channels 0..4 = 10..14, external counter clock=15. Each signal takes the lowest-numbered pin that is free. Enabling SPI claims codes 3 to 5, and enabling the two-wire bus claims codes 7 and 8.
- R5: A pin whose `skip_mask` bit is 1 never receives a code other than the fixed UART codes on pins 4 and 5.
- R6: When the UART is disabled, pins 4 and 5 are free for other signals.
- R7: NSS (code 6) is placed only when `spi_4wire` is 1. With `spi_4wire` at 0, SPI uses exactly three pins.
- R8: `cc_count` places that many capture/compare channels, lowest channel first. A value above 5 behaves as 5.
- R9: Entry k of `sig_pin` and bit k of `sig_valid` describe code k+1. When the valid bit is 1, `sig_pin` holds the pin that carries that code. When the signal is unplaced, the valid bit is 0.
- R10: Outputs change one clock after the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| uart_en | input | 1 | Primary UART enable (fixed pins) |
| spi_en | input | 1 | SPI enable |
| spi_4wire | input | 1 | 1 = slave select routed to a pin |
| twi_en | input | 1 | Two-wire bus enable |
| cmp_en | input | 1 | Comparator output enable |
| cc_count | input | 3 | Number of capture/compare channels (0..5) |
| eci_en | input | 1 | External counter clock input enable |
| skip_mask | input | 16 | 1 = pin reserved, not handed out |
| pin_sel | output | 16x4 | Per-pin select code, 0 = GPIO |
| sig_pin | output | 15x4 | Pin index for each signal code 1..15 |
| sig_valid | output | 15 | Signal placed flag for each code 1..15 |
| overflow | output | 1 | Some requested signal was left unplaced |

## Verification
A table of configurations starts with lone resources on an empty mask. This separates the fixed UART placement from the walk, and 3-wire SPI from 4-wire SPI. Fully loaded configurations follow, with zero, one and two pins skipped. They show whether every later signal shifts up by one pin, and whether the last signal drops out with `overflow` raised. Masks that cover pins 4 and 5, with and without the UART, show that the fixed placement overrides the mask and that those pins return to the pool when the UART is off. Directed cases cover channel-count saturation, the routing indices, the one-cycle latency and the reset state.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int C_GPIO   = 0;
  localparam int C_U0TX   = 1;
  localparam int C_U0RX   = 2;
  localparam int C_SCK    = 3;
  localparam int C_MISO   = 4;
  localparam int C_MOSI   = 5;
  localparam int C_NSS    = 6;
  localparam int C_SDA    = 7;
  localparam int C_SCL    = 8;
  localparam int C_CMP    = 9;
  localparam int C_CC0    = 10;
  localparam int U0TX_PIN = 4;
  localparam int U0RX_PIN = 5;
endpackage

// File: rtl/xbar_request.sv
module xbar_request #(
  parameter int CC_MAX  = 5,
  parameter int CNT_W   = 3,
  parameter int NUM_SIG = 10 + CC_MAX
) (
  input  logic               xbar_en,
  input  logic               uart_en,
  input  logic               spi_en,
  input  logic               spi_4wire,
  input  logic               twi_en,
  input  logic               cmp_en,
  input  logic [CNT_W-1:0]   cc_count,
  input  logic               eci_en,
  output logic [NUM_SIG-1:0] req
);
  import xbar_pkg::*;

  logic [CNT_W-1:0] cc_eff;

  always_comb begin
    cc_eff = (int'(cc_count) > CC_MAX) ? CNT_W'(CC_MAX) : cc_count;
    req = '0;
    if (xbar_en) begin
      req[C_U0TX-1] = uart_en;
      req[C_U0RX-1] = uart_en;
      req[C_SCK-1]  = spi_en;
      req[C_MISO-1] = spi_en;
      req[C_MOSI-1] = spi_en;
      req[C_NSS-1]  = spi_en & spi_4wire;
      req[C_SDA-1]  = twi_en;
      req[C_SCL-1]  = twi_en;
      req[C_CMP-1]  = cmp_en;
      for (int j = 0; j < CC_MAX; j++)
        req[C_CC0-1+j] = (j < int'(cc_eff));
      req[C_CC0-1+CC_MAX] = eci_en;
    end
  end
endmodule

// File: rtl/xbar_lowest_free.sv
module xbar_lowest_free #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_io_crossbar.sv
module prio_io_crossbar #(
  parameter int NUM_PINS = 16,
  parameter int CC_MAX   = 5,
  parameter int CNT_W    = 3,
  parameter int NUM_SIG  = 10 + CC_MAX,
  parameter int CODE_W   = $clog2(NUM_SIG + 1),
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             xbar_en,
  input  logic                             uart_en,
  input  logic                             spi_en,
  input  logic                             spi_4wire,
  input  logic                             twi_en,
  input  logic                             cmp_en,
  input  logic [CNT_W-1:0]                 cc_count,
  input  logic                             eci_en,
  input  logic [NUM_PINS-1:0]              skip_mask,
  output logic [NUM_PINS-1:0][CODE_W-1:0]  pin_sel,
  output logic [NUM_SIG-1:0][PIN_W-1:0]    sig_pin,
  output logic [NUM_SIG-1:0]               sig_valid,
  output logic                             overflow
);
  import xbar_pkg::*;

  localparam logic [NUM_PINS-1:0] ONE_HOT0 = {{(NUM_PINS-1){1'b0}}, 1'b1};
  localparam logic [NUM_PINS-1:0] UART_PINS =
    (ONE_HOT0 << U0TX_PIN) | (ONE_HOT0 << U0RX_PIN);

  logic [NUM_SIG-1:0]  req;
  logic [NUM_PINS-1:0] busy_chain [NUM_SIG+1];
  logic [PIN_W-1:0]    pin_c      [NUM_SIG];
  logic                valid_c    [NUM_SIG];
  logic                miss_c     [NUM_SIG];

  xbar_request #(.CC_MAX(CC_MAX), .CNT_W(CNT_W), .NUM_SIG(NUM_SIG)) u_req (
    .xbar_en(xbar_en), .uart_en(uart_en), .spi_en(spi_en),
    .spi_4wire(spi_4wire), .twi_en(twi_en), .cmp_en(cmp_en),
    .cc_count(cc_count), .eci_en(eci_en), .req(req)
  );

  // Fixed UART pins count as taken only while the UART is actually requested.
  assign busy_chain[0] = skip_mask | (req[C_U0TX-1] ? UART_PINS : '0);

  for (genvar k = 0; k < NUM_SIG; k++) begin : g_stage
    if (k + 1 == C_U0TX || k + 1 == C_U0RX) begin : g_fixed
      assign pin_c[k]        = PIN_W'((k + 1 == C_U0TX) ? U0TX_PIN : U0RX_PIN);
      assign valid_c[k]      = req[k];
      assign miss_c[k]       = 1'b0;
      assign busy_chain[k+1] = busy_chain[k];
    end else begin : g_walk
      logic found;
      logic [PIN_W-1:0] idx;
      xbar_lowest_free #(.N(NUM_PINS), .IDX_W(PIN_W)) u_free (
        .busy(busy_chain[k]), .found(found), .idx(idx)
      );
      assign pin_c[k]        = idx;
      assign valid_c[k]      = req[k] & found;
      assign miss_c[k]       = req[k] & ~found;
      assign busy_chain[k+1] = busy_chain[k] | (valid_c[k] ? (ONE_HOT0 << idx) : '0);
    end
  end

  logic [NUM_PINS-1:0][CODE_W-1:0] nxt_sel;
  logic [NUM_SIG-1:0][PIN_W-1:0]   nxt_pin;
  logic [NUM_SIG-1:0]              nxt_valid;
  logic                            nxt_ovf;

  always_comb begin
    nxt_sel = '0;
    nxt_ovf = 1'b0;
    for (int k = 0; k < NUM_SIG; k++) begin
      nxt_valid[k] = valid_c[k];
      nxt_pin[k]   = valid_c[k] ? pin_c[k] : '0;
      nxt_ovf      = nxt_ovf | miss_c[k];
      if (valid_c[k]) nxt_sel[pin_c[k]] = CODE_W'(k + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sel   <= '0;
      sig_pin   <= '0;
      sig_valid <= '0;
      overflow  <= 1'b0;
    end else begin
      pin_sel   <= nxt_sel;
      sig_pin   <= nxt_pin;
      sig_valid <= nxt_valid;
      overflow  <= nxt_ovf;
    end
  end
endmodule

// File: rtl/prio_io_crossbar_chk.sv
module prio_io_crossbar_chk #(
  parameter int NUM_PINS = 16,
  parameter int CC_MAX   = 5,
  parameter int CNT_W    = 3,
  parameter int NUM_SIG  = 10 + CC_MAX,
  parameter int CODE_W   = $clog2(NUM_SIG + 1),
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             xbar_en,
  input logic                             uart_en,
  input logic                             spi_en,
  input logic                             spi_4wire,
  input logic                             twi_en,
  input logic                             cmp_en,
  input logic [CNT_W-1:0]                 cc_count,
  input logic                             eci_en,
  input logic [NUM_PINS-1:0]              skip_mask,
  input logic [NUM_PINS-1:0][CODE_W-1:0]  pin_sel,
  input logic [NUM_SIG-1:0][PIN_W-1:0]    sig_pin,
  input logic [NUM_SIG-1:0]               sig_valid,
  input logic                             overflow
);
  logic [NUM_PINS-1:0] pin_nz;
  logic [NUM_PINS-1:0] uart_keep;

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) pin_nz[p] = |pin_sel[p];
    uart_keep = '0;
    uart_keep[4] = 1'b1;
    uart_keep[5] = 1'b1;
  end

  assert_gpio_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(xbar_en)) |-> (pin_sel == '0 && sig_valid == '0 && !overflow));

  assert_uart_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(xbar_en && uart_en)) |->
      (pin_sel[4] == CODE_W'(1) && pin_sel[5] == CODE_W'(2)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && overflow) |-> ((pin_nz | $past(skip_mask)) == '1));

  assert_skip_honoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pin_nz & $past(skip_mask) & ~uart_keep) == '0));

  assert_nss_3wire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(spi_4wire)) |-> !sig_valid[5]);

  for (genvar k = 0; k < NUM_SIG; k++) begin : g_route
    assert_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sig_valid[k] |-> (pin_sel[sig_pin[k]] == CODE_W'(k + 1)));
  end
endmodule

bind prio_io_crossbar prio_io_crossbar_chk #(
  .NUM_PINS(NUM_PINS), .CC_MAX(CC_MAX), .CNT_W(CNT_W),
  .NUM_SIG(NUM_SIG), .CODE_W(CODE_W), .PIN_W(PIN_W)
) u_chk (.*);

// File: tb/prio_io_crossbar_test.sv
module prio_io_crossbar_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xbar_en = 0, uart_en = 0, spi_en = 0, spi_4wire = 0;
  logic twi_en = 0, cmp_en = 0, eci_en = 0;
  logic [2:0]  cc_count = '0;
  logic [15:0] skip_mask = '0;
  logic [15:0][3:0] pin_sel;
  logic [14:0][3:0] sig_pin;
  logic [14:0] sig_valid;
  logic overflow;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prio_io_crossbar uut (
    .clk(clk), .rst_n(rst_n), .xbar_en(xbar_en), .uart_en(uart_en),
    .spi_en(spi_en), .spi_4wire(spi_4wire), .twi_en(twi_en), .cmp_en(cmp_en),
    .cc_count(cc_count), .eci_en(eci_en), .skip_mask(skip_mask),
    .pin_sel(pin_sel), .sig_pin(sig_pin), .sig_valid(sig_valid), .overflow(overflow)
  );

  typedef struct packed {
    logic xb, ua, sp, w4, tw, cm;
    logic [2:0] cc;
    logic ec;
    logic [15:0] skip;
    logic [63:0] exp_sel;
    logic exp_ovf;
  } vec_t;

  // Expected pin codes: hex digit n (from the right) is the code on pin n.
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,0,0,3'd0,0,16'h0000,64'h0000_0000_0000_0000,0},
    '{1,1,0,0,0,0,3'd0,0,16'h0000,64'h0000_0000_0021_0000,0},
    '{1,1,1,0,0,0,3'd0,0,16'h0000,64'h0000_0000_0021_0543,0},
    '{1,0,1,1,0,0,3'd0,0,16'h0000,64'h0000_0000_0000_6543,0},
    '{1,1,1,1,1,1,3'd5,1,16'h0000,64'h0FED_CBA9_8721_6543,0},
    '{1,1,1,1,1,1,3'd5,1,16'h0001,64'hFEDC_BA98_7621_5430,0},
    '{1,1,1,1,1,1,3'd5,1,16'h0003,64'hEDCB_A987_6521_4300,1},
    '{1,1,0,0,1,0,3'd0,0,16'h0030,64'h0000_0000_0021_0087,0},
    '{1,0,0,0,0,1,3'd0,0,16'h000F,64'h0000_0000_0009_0000,0},
    '{0,1,1,1,1,1,3'd5,1,16'h0000,64'h0000_0000_0000_0000,0},
    '{1,0,0,0,0,0,3'd7,0,16'h0000,64'h0000_0000_000E_DCBA,0},
    '{1,0,0,0,0,0,3'd2,1,16'h0000,64'h0000_0000_0000_0FBA,0}
  };
  localparam string TAGS [NV] = '{
    "R4 idle", "R2 uart alone", "R7 R4 spi 3-wire", "R7 R6 spi 4-wire",
    "R4 full load", "R5 one skip", "R3 two skips", "R2 R5 uart over skip",
    "R6 R5 pins 4/5 free", "R1 disabled", "R8 saturate", "R8 two channels"
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    xbar_en = v.xb; uart_en = v.ua; spi_en = v.sp; spi_4wire = v.w4;
    twi_en = v.tw; cmp_en = v.cm; cc_count = v.cc; eci_en = v.ec;
    skip_mask = v.skip;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs held at GPIO while reset is low
    chk(pin_sel == '0 && !overflow && sig_valid == '0, "R10 reset state",
        64'(pin_sel), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk(pin_sel == VECS[i].exp_sel, TAGS[i], 64'(pin_sel), VECS[i].exp_sel);
      chk(overflow == VECS[i].exp_ovf, {TAGS[i], " overflow"},
          64'(overflow), 64'(VECS[i].exp_ovf));
    end

    // R9: routing indices for the full-load case
    drive(VECS[4]);
    chk(sig_valid[6] && sig_pin[6] == 4'd6, "R9 SDA route", 64'(sig_pin[6]), 64'd6);
    chk(sig_valid[14] && sig_pin[14] == 4'd14, "R9 ECI route", 64'(sig_pin[14]), 64'd14);
    chk(sig_valid[0] && sig_pin[0] == 4'd4, "R9 UART TX route", 64'(sig_pin[0]), 64'd4);

    // R9 R3: the unplaced counter clock has no valid route
    drive(VECS[6]);
    chk(!sig_valid[14], "R9 unplaced ECI", 64'(sig_valid[14]), 64'd0);

    // R7: NSS never routed in 3-wire mode
    drive(VECS[2]);
    chk(!sig_valid[5], "R7 NSS valid", 64'(sig_valid[5]), 64'd0);

    // R10: one-cycle latency, old value visible just after the input change
    @(negedge clk);
    spi_4wire = 1'b1;
    #1;
    chk(pin_sel == VECS[2].exp_sel, "R10 latency hold", 64'(pin_sel), VECS[2].exp_sel);
    @(negedge clk);
    chk(pin_sel[3] == 4'd6, "R10 latency update", 64'(pin_sel[3]), 64'd6);

    // R10: reset mid-run clears a loaded configuration
    drive(VECS[4]);
    rst_n = 1'b0;
    #1;
    chk(pin_sel == '0 && sig_valid == '0, "R10 mid-run reset", 64'(pin_sel), 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule